// File: doc/BRIEF.md
# Flow-Controlled Serial Transceiver

This block moves bytes over an asynchronous serial line. A transmit section takes bytes through a valid/ready handshake and sends each one as a frame. The frame is a low start bit, eight data bits with the least significant bit first, and a high stop bit. A receive section finds frames on the incoming line, checks the start and stop bits, and places each good byte into an eight-entry receive queue. The queue is read through its own valid/ready handshake. Every bit lasts sixteen pulses of an external oversampling tick.

A small control word turns the two sections on and off. It holds a master enable, one enable per direction, and two flow-control options:

- **Clear-to-send gating.** A new outgoing frame starts only while the active-low clear-to-send input is asserted.
- **Request-to-send.** The active-low request-to-send output reports whether the receive queue has room.

Clearing an enable, or losing clear-to-send, never shortens a frame that has already started. The frame runs to its stop bit and only the next one is held back.

Top module: `fcuart_core`

## Requirements
- R1: After reset the control word reads 0x0300: master enable (bit 0) clear, transmit enable (bit 8) set, receive enable (bit 9) set, request-to-send option (bit 14) clear, clear-to-send option (bit 15) clear. A write stores only those five bits, the other bits always read 0, and the new value appears on the read port one cycle after the write.
- R2: The transmit line idles high. Each accepted byte goes out as one low start bit, eight data bits with the LSB first, and one high stop bit. Each bit lasts 16 baud ticks.
- R3: A byte is accepted (tx_ready_o high) only while both the master enable and the transmit enable are set. Clearing either one during a frame lets that frame complete with correct content, and no further frame starts.
- R4: While the clear-to-send option is set, a new frame starts only while cts_n_i is low. Raising cts_n_i during a frame does not abort that frame.
- R5: The receiver samples each bit at its middle (8 ticks after the start edge, then every 16 ticks). A low level that is gone by the mid-start check is ignored. A frame whose stop bit is low is discarded.
- R6: A new incoming frame is accepted only while both the master enable and the receive enable are set. Clearing either one during a frame still delivers that byte.
- R7: The receive queue holds 8 bytes and returns them in arrival order. A byte that completes while the queue holds 8 is dropped.
- R8: With the request-to-send option set, rts_n_i... rts_n_o is high exactly when the queue holds 8 bytes. With the option clear, rts_n_o stays low.
- R9: rx_valid_o stays high, with rx_data_o unchanged, until the head byte is taken with rx_ready_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick_i | input | 1 | One-cycle pulse at 16 times the bit rate |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 16 | Control word write value |
| ctl_rdata_o | output | 16 | Current control word |
| tx_data_i | input | 8 | Byte to send |
| tx_valid_i | input | 1 | Byte to send is present |
| tx_ready_o | output | 1 | Transmitter accepts the byte this cycle |
| txd_o | output | 1 | Serial output line |
| rxd_i | input | 1 | Serial input line (asynchronous) |
| cts_n_i | input | 1 | Clear-to-send, active low (asynchronous) |
| rts_n_o | output | 1 | Request-to-send, active low |
| rx_data_o | output | 8 | Head byte of the receive queue |
| rx_valid_o | output | 1 | Receive queue not empty |
| rx_ready_i | input | 1 | Take the head byte |

## Verification
The bench builds the block with its default parameters: 8 data bits, 16 ticks per bit, an 8-entry queue and two synchroniser stages. It drives one baud tick every four clocks, so a full frame takes 640 clocks. That rate makes it practical to fill the queue past its depth, to hold a byte through two frame times while an enable or clear-to-send blocks it, and to clear an enable several bit times into a frame. The two-stage synchroniser delay is small against the eight-tick margin to mid-bit, so the bench's bit-aligned line driver always lands its samples inside the intended bit.

// File: rtl/fcuart_pkg.sv
package fcuart_pkg;

    localparam int CTL_W         = 16;
    localparam int CTL_BIT_GLOB  = 0;
    localparam int CTL_BIT_TXEN  = 8;
    localparam int CTL_BIT_RXEN  = 9;
    localparam int CTL_BIT_RTSFC = 14;
    localparam int CTL_BIT_CTSFC = 15;

    localparam logic [CTL_W-1:0] CTL_RESET = 16'h0300;
    localparam logic [CTL_W-1:0] CTL_MASK  =
        (CTL_W'(1) << CTL_BIT_GLOB)  | (CTL_W'(1) << CTL_BIT_TXEN) |
        (CTL_W'(1) << CTL_BIT_RXEN)  | (CTL_W'(1) << CTL_BIT_RTSFC) |
        (CTL_W'(1) << CTL_BIT_CTSFC);

    typedef struct packed {
        logic cts_fc;
        logic rts_fc;
        logic rx_en;
        logic tx_en;
        logic glob_en;
    } ctl_t;

    typedef enum logic [1:0] {
        LN_IDLE  = 2'd0,
        LN_START = 2'd1,
        LN_DATA  = 2'd2,
        LN_STOP  = 2'd3
    } line_state_t;

    function automatic ctl_t ctl_decode(input logic [CTL_W-1:0] w);
        ctl_t c;
        c.glob_en = w[CTL_BIT_GLOB];
        c.tx_en   = w[CTL_BIT_TXEN];
        c.rx_en   = w[CTL_BIT_RXEN];
        c.rts_fc  = w[CTL_BIT_RTSFC];
        c.cts_fc  = w[CTL_BIT_CTSFC];
        return c;
    endfunction

    function automatic logic [CTL_W-1:0] ctl_encode(input ctl_t c);
        logic [CTL_W-1:0] w;
        w                = '0;
        w[CTL_BIT_GLOB]  = c.glob_en;
        w[CTL_BIT_TXEN]  = c.tx_en;
        w[CTL_BIT_RXEN]  = c.rx_en;
        w[CTL_BIT_RTSFC] = c.rts_fc;
        w[CTL_BIT_CTSFC] = c.cts_fc;
        return w;
    endfunction

endpackage

// File: rtl/fcuart_sync.sv
module fcuart_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] ff;

    always_ff @(posedge clk) begin
        if (rst) ff <= {STAGES{RST_VAL}};
        else     ff <= {ff[STAGES-2:0], d_i};
    end

    assign q_o = ff[STAGES-1];
endmodule

// File: rtl/fcuart_tx.sv
module fcuart_tx
    import fcuart_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              en_i,
    input  logic              cts_ok_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              valid_i,
    output logic              ready_o,
    output logic              txd_o
);
    localparam int CNT_W = $clog2(OVS);
    localparam int BIT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

    line_state_t       st;
    logic [CNT_W-1:0]  cnt;
    logic [BIT_W-1:0]  bidx;
    logic [DATA_W-1:0] sh;

    // A new frame may only begin from idle with both gates open.
    assign ready_o = (st == LN_IDLE) && en_i && cts_ok_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= LN_IDLE;
            cnt  <= '0;
            bidx <= '0;
            sh   <= '0;
        end else if (st == LN_IDLE) begin
            if (valid_i && ready_o) begin
                sh  <= data_i;
                cnt <= '0;
                st  <= LN_START;
            end
        end else if (tick_i) begin
            if (cnt == CNT_LAST) begin
                cnt <= '0;
                case (st)
                    LN_START: begin
                        st   <= LN_DATA;
                        bidx <= '0;
                    end
                    LN_DATA: begin
                        sh <= sh >> 1;
                        if (bidx == BIT_LAST) st <= LN_STOP;
                        else                  bidx <= bidx + 1'b1;
                    end
                    default: st <= LN_IDLE;
                endcase
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    always_comb begin
        case (st)
            LN_START: txd_o = 1'b0;
            LN_DATA:  txd_o = sh[0];
            default:  txd_o = 1'b1;
        endcase
    end

    a_r3_start_needs_enable: assert property (@(posedge clk) disable iff (rst)
        (st == LN_START && $past(st) == LN_IDLE) |-> $past(en_i));
    a_r4_start_needs_cts: assert property (@(posedge clk) disable iff (rst)
        (st == LN_START && $past(st) == LN_IDLE) |-> $past(cts_ok_i));
    a_r3_frame_not_cut: assert property (@(posedge clk) disable iff (rst)
        (st == LN_DATA) |=> (st != LN_IDLE));
    a_r2_moves_on_tick: assert property (@(posedge clk) disable iff (rst)
        (st != LN_IDLE && !tick_i) |=> (st == $past(st)));
endmodule

// File: rtl/fcuart_rx.sv
module fcuart_rx
    import fcuart_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              en_i,
    input  logic              rxd_i,
    output logic [DATA_W-1:0] data_o,
    output logic              push_o
);
    localparam int CNT_W = $clog2(OVS);
    localparam int BIT_W = $clog2(DATA_W + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
    localparam logic [CNT_W-1:0] CNT_MID  = CNT_W'(OVS / 2 - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

    line_state_t       st;
    logic [CNT_W-1:0]  cnt;
    logic [BIT_W-1:0]  bidx;
    logic [DATA_W-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= LN_IDLE;
            cnt    <= '0;
            bidx   <= '0;
            sh     <= '0;
            push_o <= 1'b0;
        end else begin
            push_o <= 1'b0;
            if (tick_i) begin
                case (st)
                    LN_IDLE: begin
                        if (en_i && !rxd_i) begin
                            st  <= LN_START;
                            cnt <= '0;
                        end
                    end
                    LN_START: begin
                        if (cnt == CNT_MID) begin
                            cnt  <= '0;
                            bidx <= '0;
                            st   <= rxd_i ? LN_IDLE : LN_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    LN_DATA: begin
                        if (cnt == CNT_LAST) begin
                            cnt <= '0;
                            sh  <= {rxd_i, sh[DATA_W-1:1]};
                            if (bidx == BIT_LAST) st <= LN_STOP;
                            else                  bidx <= bidx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: begin
                        if (cnt == CNT_LAST) begin
                            cnt    <= '0;
                            push_o <= rxd_i;
                            st     <= LN_IDLE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                endcase
            end
        end
    end

    assign data_o = sh;

    a_r6_start_needs_enable: assert property (@(posedge clk) disable iff (rst)
        (st == LN_START && $past(st) == LN_IDLE) |-> $past(en_i));
    a_r6_frame_not_cut: assert property (@(posedge clk) disable iff (rst)
        (st == LN_DATA) |=> (st != LN_IDLE));
    a_r5_push_after_stop: assert property (@(posedge clk) disable iff (rst)
        push_o |-> ($past(st) == LN_STOP && $past(rxd_i)));
endmodule

// File: rtl/fcuart_fifo.sv
module fcuart_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push_i,
    input  logic [W-1:0] data_i,
    input  logic         pop_i,
    output logic [W-1:0] data_o,
    output logic         valid_o,
    output logic         full_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push, do_pop;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + 1'b1;
    endfunction

    assign full_o  = (count == CNT_FULL);
    assign valid_o = (count != '0);
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && valid_o;
    assign data_o  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= data_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= ptr_next(wr_ptr);
            if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_FULL);
    a_r7_full_drop: assert property (@(posedge clk) disable iff (rst)
        (full_o && push_i && !pop_i) |=> (full_o && $stable(wr_ptr)));
    a_r9_valid_held: assert property (@(posedge clk) disable iff (rst)
        (valid_o && !pop_i) |=> (valid_o && $stable(rd_ptr)));
endmodule

// File: rtl/fcuart_core.sv
module fcuart_core
    import fcuart_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int OVS         = 16,
    parameter int FIFO_DEPTH  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              baud_tick_i,
    input  logic              ctl_we_i,
    input  logic [CTL_W-1:0]  ctl_wdata_i,
    output logic [CTL_W-1:0]  ctl_rdata_o,
    input  logic [DATA_W-1:0] tx_data_i,
    input  logic              tx_valid_i,
    output logic              tx_ready_o,
    output logic              txd_o,
    input  logic              rxd_i,
    input  logic              cts_n_i,
    output logic              rts_n_o,
    output logic [DATA_W-1:0] rx_data_o,
    output logic              rx_valid_o,
    input  logic              rx_ready_i
);
    ctl_t              ctl_q;
    logic              rxd_s, cts_n_s;
    logic              tx_en, rx_en, cts_ok;
    logic [DATA_W-1:0] rx_byte;
    logic              rx_push, fifo_full;

    always_ff @(posedge clk) begin
        if (rst)           ctl_q <= ctl_decode(CTL_RESET);
        else if (ctl_we_i) ctl_q <= ctl_decode(ctl_wdata_i);
    end
    assign ctl_rdata_o = ctl_encode(ctl_q);

    fcuart_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_rxd (
        .clk(clk), .rst(rst), .d_i(rxd_i), .q_o(rxd_s));
    fcuart_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cts (
        .clk(clk), .rst(rst), .d_i(cts_n_i), .q_o(cts_n_s));

    assign tx_en  = ctl_q.glob_en && ctl_q.tx_en;
    assign rx_en  = ctl_q.glob_en && ctl_q.rx_en;
    assign cts_ok = !ctl_q.cts_fc || !cts_n_s;

    fcuart_tx #(.DATA_W(DATA_W), .OVS(OVS)) u_tx (
        .clk(clk), .rst(rst), .tick_i(baud_tick_i), .en_i(tx_en),
        .cts_ok_i(cts_ok), .data_i(tx_data_i), .valid_i(tx_valid_i),
        .ready_o(tx_ready_o), .txd_o(txd_o));

    fcuart_rx #(.DATA_W(DATA_W), .OVS(OVS)) u_rx (
        .clk(clk), .rst(rst), .tick_i(baud_tick_i), .en_i(rx_en),
        .rxd_i(rxd_s), .data_o(rx_byte), .push_o(rx_push));

    fcuart_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk(clk), .rst(rst), .push_i(rx_push), .data_i(rx_byte),
        .pop_i(rx_ready_i), .data_o(rx_data_o), .valid_o(rx_valid_o),
        .full_o(fifo_full));

    assign rts_n_o = ctl_q.rts_fc ? fifo_full : 1'b0;

    a_r1_write_visible: assert property (@(posedge clk) disable iff (rst)
        $past(ctl_we_i) |-> (ctl_rdata_o == ($past(ctl_wdata_i) & CTL_MASK)));
    a_r8_rts_needs_option: assert property (@(posedge clk) disable iff (rst)
        rts_n_o |-> ctl_q.rts_fc);
    a_r9_data_held: assert property (@(posedge clk) disable iff (rst)
        (rx_valid_o && !rx_ready_i) |=> (rx_valid_o && $stable(rx_data_o)));
endmodule

// File: tb/fcuart_core_tb_top.sv
`timescale 1ns/1ps
module fcuart_core_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        baud_tick = 1'b0;
    logic [1:0]  tick_div = '0;
    logic        ctl_we = 1'b0;
    logic [15:0] ctl_wdata = '0;
    logic [15:0] ctl_rdata;
    logic [7:0]  tx_data = '0;
    logic        tx_valid = 1'b0;
    logic        tx_ready;
    logic        txd;
    logic        rxd = 1'b1;
    logic        cts_n = 1'b1;
    logic        rts_n;
    logic [7:0]  rx_data;
    logic        rx_valid;
    logic        rx_ready = 1'b0;

    int compared = 0;
    int mismatched = 0;
    int tx_frames = 0;
    int rx_bytes = 0;
    bit drain_en = 1'b0;
    logic [7:0] exp_tx[$];
    logic [7:0] exp_rx[$];

    always #10 clk = ~clk;

    always @(posedge clk) begin
        tick_div  <= tick_div + 2'd1;
        baud_tick <= (tick_div == 2'd3);
    end

    fcuart_core dut_i (
        .clk(clk), .rst(rst), .baud_tick_i(baud_tick),
        .ctl_we_i(ctl_we), .ctl_wdata_i(ctl_wdata), .ctl_rdata_o(ctl_rdata),
        .tx_data_i(tx_data), .tx_valid_i(tx_valid), .tx_ready_o(tx_ready),
        .txd_o(txd), .rxd_i(rxd), .cts_n_i(cts_n), .rts_n_o(rts_n),
        .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rx_ready_i(rx_ready));

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        for (int k = 0; k < n; k++) begin
            do @(negedge clk); while (baud_tick !== 1'b1);
        end
    endtask

    task automatic write_ctl(input logic [15:0] v);
        @(negedge clk);
        ctl_we = 1'b1;
        ctl_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic send_tx(input logic [7:0] b);
        exp_tx.push_back(b);
        @(negedge clk);
        tx_valid = 1'b1;
        tx_data = b;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
    endtask

    task automatic wait_tx_drained();
        while (exp_tx.size() != 0) @(negedge clk);
        repeat (100) @(negedge clk);
    endtask

    task automatic send_rx(input logic [7:0] b, input logic stop_bit);
        wait_ticks(1);
        rxd = 1'b0;
        wait_ticks(16);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            wait_ticks(16);
        end
        rxd = stop_bit;
        wait_ticks(16);
        rxd = 1'b1;
        wait_ticks(4);
    endtask

    // Transmit monitor: decodes frames on txd and scores them.
    initial begin
        logic [7:0] got;
        logic       sb, pb;
        forever begin
            @(negedge clk);
            if (!rst && txd === 1'b0) begin
                wait_ticks(8);
                sb = txd;
                for (int i = 0; i < 8; i++) begin
                    wait_ticks(16);
                    got[i] = txd;
                end
                wait_ticks(16);
                pb = txd;
                tx_frames++;
                check(sb == 1'b0 && pb == 1'b1, "R2 start/stop levels",
                      {30'd0, sb, pb}, 32'h1);
                if (exp_tx.size() == 0) begin
                    check(1'b0, "R3 unexpected tx frame", {24'd0, got}, 32'h0);
                end else begin
                    logic [7:0] e;
                    e = exp_tx.pop_front();
                    check(got == e, "R2 tx byte", {24'd0, got}, {24'd0, e});
                end
            end
        end
    end

    // Receive consumer: pops the queue and scores bytes.
    initial begin
        forever begin
            @(negedge clk);
            if (drain_en && rx_valid) begin
                rx_bytes++;
                if (exp_rx.size() == 0) begin
                    check(1'b0, "R6 unexpected rx byte", {24'd0, rx_data}, 32'h0);
                end else begin
                    logic [7:0] e;
                    e = exp_rx.pop_front();
                    check(rx_data == e, "R7 rx byte order", {24'd0, rx_data}, {24'd0, e});
                end
                rx_ready = 1'b1;
                @(negedge clk);
                rx_ready = 1'b0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog", 32'd0, 32'd1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        int f0;
        int r0;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 / reset state
        check(ctl_rdata == 16'h0300, "R1 reset value", {16'd0, ctl_rdata}, 32'h0300);
        check(txd == 1'b1, "R2 idle line high", {31'd0, txd}, 32'h1);
        check(tx_ready == 1'b0, "R3 ready low with master off", {31'd0, tx_ready}, 32'h0);
        check(rts_n == 1'b0, "R8 rts low with option clear", {31'd0, rts_n}, 32'h0);
        check(rx_valid == 1'b0, "R9 queue empty after reset", {31'd0, rx_valid}, 32'h0);

        write_ctl(16'hFFFF);
        check(ctl_rdata == 16'hC301, "R1 only five bits stored", {16'd0, ctl_rdata}, 32'hC301);
        write_ctl(16'h0301);
        check(ctl_rdata == 16'h0301, "R1 readback", {16'd0, ctl_rdata}, 32'h0301);

        // R2: several byte patterns, back to back
        send_tx(8'hA5);
        send_tx(8'h00);
        send_tx(8'hFF);
        send_tx(8'h3C);
        wait_tx_drained();
        check(tx_frames == 4, "R2 frame count", tx_frames, 32'd4);

        // R3: transmit enable off blocks a pending byte
        write_ctl(16'h0201);
        f0 = tx_frames;
        @(negedge clk);
        tx_valid = 1'b1;
        tx_data = 8'h77;
        repeat (1300) @(negedge clk);
        check(tx_ready == 1'b0, "R3 ready low with tx enable off", {31'd0, tx_ready}, 32'h0);
        check(tx_frames == f0, "R3 no frame with tx enable off", tx_frames, f0);
        tx_valid = 1'b0;

        // R3: master off mid-frame lets the frame finish
        write_ctl(16'h0301);
        f0 = tx_frames;
        send_tx(8'h5A);
        wait_ticks(40);
        write_ctl(16'h0300);
        wait_tx_drained();
        check(tx_frames == f0 + 1, "R3 frame completes after disable", tx_frames, f0 + 1);
        check(tx_ready == 1'b0, "R3 stopped after frame", {31'd0, tx_ready}, 32'h0);

        // R4: clear-to-send gating
        write_ctl(16'h8301);
        cts_n = 1'b1;
        f0 = tx_frames;
        exp_tx.push_back(8'h81);
        @(negedge clk);
        tx_valid = 1'b1;
        tx_data = 8'h81;
        repeat (1300) @(negedge clk);
        check(tx_frames == f0, "R4 held while cts high", tx_frames, f0);
        check(tx_ready == 1'b0, "R4 ready low while cts high", {31'd0, tx_ready}, 32'h0);
        cts_n = 1'b0;
        while (!tx_ready) @(negedge clk);
        @(negedge clk);
        tx_valid = 1'b0;
        wait_tx_drained();
        check(tx_frames == f0 + 1, "R4 sent after cts low", tx_frames, f0 + 1);

        f0 = tx_frames;
        send_tx(8'h7E);
        wait_ticks(40);
        cts_n = 1'b1;
        @(negedge clk);
        tx_valid = 1'b1;
        tx_data = 8'h11;
        wait_tx_drained();
        repeat (1300) @(negedge clk);
        check(tx_frames == f0 + 1, "R4 frame not aborted, next held", tx_frames, f0 + 1);
        tx_valid = 1'b0;
        cts_n = 1'b0;
        write_ctl(16'h0301);

        // R5: receive patterns
        drain_en = 1'b1;
        exp_rx.push_back(8'h3A);
        send_rx(8'h3A, 1'b1);
        exp_rx.push_back(8'hC5);
        send_rx(8'hC5, 1'b1);
        repeat (20) @(negedge clk);
        check(exp_rx.size() == 0 && rx_bytes == 2, "R5 bytes received",
              rx_bytes, 32'd2);

        r0 = rx_bytes;
        wait_ticks(1);
        rxd = 1'b0;
        wait_ticks(3);
        rxd = 1'b1;
        wait_ticks(40);
        check(rx_bytes == r0, "R5 short low pulse ignored", rx_bytes, r0);
        send_rx(8'h99, 1'b0);
        wait_ticks(20);
        check(rx_bytes == r0, "R5 low stop bit discarded", rx_bytes, r0);

        // R6: receive enable
        write_ctl(16'h0101);
        send_rx(8'h44, 1'b1);
        repeat (20) @(negedge clk);
        check(rx_bytes == r0 && rx_valid == 1'b0, "R6 nothing while rx disabled",
              rx_bytes, r0);
        write_ctl(16'h0301);
        exp_rx.push_back(8'h6B);
        fork
            send_rx(8'h6B, 1'b1);
            begin
                wait_ticks(50);
                write_ctl(16'h0101);
            end
        join
        repeat (20) @(negedge clk);
        check(rx_bytes == r0 + 1 && exp_rx.size() == 0, "R6 byte completes after disable",
              rx_bytes, r0 + 1);

        // R7 / R8 / R9: fill the queue
        write_ctl(16'h4301);
        drain_en = 1'b0;
        check(rts_n == 1'b0, "R8 rts low while empty", {31'd0, rts_n}, 32'h0);
        for (int i = 0; i < 8; i++) begin
            logic [7:0] b;
            b = 8'h10 + 8'(i * 17);
            exp_rx.push_back(b);
            send_rx(b, 1'b1);
            if (i == 6)
                check(rts_n == 1'b0, "R8 rts low at seven", {31'd0, rts_n}, 32'h0);
        end
        @(negedge clk);
        check(rts_n == 1'b1, "R8 rts high when full", {31'd0, rts_n}, 32'h1);
        send_rx(8'hEE, 1'b1);
        repeat (100) @(negedge clk);
        check(rx_valid == 1'b1 && rx_data == 8'h10, "R9 head held until popped",
              {24'd0, rx_data}, 32'h10);
        write_ctl(16'h0301);
        check(rts_n == 1'b0, "R8 rts low with option cleared", {31'd0, rts_n}, 32'h0);
        write_ctl(16'h4301);
        check(rts_n == 1'b1, "R8 rts high again", {31'd0, rts_n}, 32'h1);

        @(negedge clk);
        begin
            logic [7:0] e;
            e = exp_rx.pop_front();
            check(rx_data == e, "R7 first byte", {24'd0, rx_data}, {24'd0, e});
        end
        rx_ready = 1'b1;
        @(negedge clk);
        rx_ready = 1'b0;
        check(rts_n == 1'b0, "R8 rts low after one pop", {31'd0, rts_n}, 32'h0);

        r0 = rx_bytes;
        drain_en = 1'b1;
        repeat (60) @(negedge clk);
        check(rx_bytes == r0 + 7 && exp_rx.size() == 0, "R7 seven left, overflow dropped",
              rx_bytes, r0 + 7);
        check(rx_valid == 1'b0, "R7 queue empty after drain", {31'd0, rx_valid}, 32'h0);
        check(exp_tx.size() == 0, "R2 no pending tx", exp_tx.size(), 32'd0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule